// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a programmable sum-of-products plane. Each logic input is buffered into a true and a complement literal. A programmable AND plane builds product terms from any mix of those literals. A fixed OR plane then merges each run of eight consecutive product terms into one sum output, one sum per macrocell slot. The register stage that would normally follow each sum is not part of this block.

The connection pattern is held in an internal configuration image. The image is shifted in one bit per clock while a load enable is held high. The outputs are declared valid only once a complete, unbroken load has finished. After that, the path from `data_in` to `term_out` and `sum_out` is purely combinational, with no clock in the path. Starting a new load withdraws validity at once. While the image is not valid, every output is held at zero.

Top module: `sop_array`

## Requirements
- R1: After a synchronous active-low reset, `cfg_valid` is 0 and every bit of `term_out` and `sum_out` is 0.
- R2: Bit k of the serial stream, shifted in on the k-th clock with `cfg_load` high, lands at image index k. For macrocell m, term t and input i, image index ((m*TERMS+t)*N_IN+i)*2 connects the true literal of input i, and the next index up connects its complement. A 1 means the literal is connected. `cfg_valid` is 0 during the load and becomes 1 at the clock edge that shifts in bit CFG_BITS-1.
- R3: If `cfg_load` drops before CFG_BITS bits have been shifted, the count is discarded and `cfg_valid` stays 0. The next load starts again from bit 0.
- R4: While `cfg_valid` is 0, `term_out` and `sum_out` are all zeros. Shifting a bit into a valid image clears `cfg_valid` at that same edge.
- R5: A product term with none of its 2*N_IN bits set evaluates to 1 for every input value.
- R6: A term whose only set bit is the true bit of input i follows `data_in[i]`. A term whose only set bit is the complement bit follows `~data_in[i]`.
- R7: A term with both the true and complement bits of any one input set is 0 for every input value.
- R8: In general, a term equals the AND of all its connected literals. It is exposed on `term_out[m*TERMS+t]`.
- R9: `sum_out[m]` is the OR of terms m*TERMS through m*TERMS+TERMS-1. No other term affects it.
- R10: Once the image is valid and `cfg_load` is low, `term_out` and `sum_out` follow changes on `data_in` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load enable; shifts `cfg_bit` in each clock while high |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_valid | output | 1 | Complete image loaded; outputs meaningful |
| data_in | input | N_IN | Logic inputs |
| term_out | output | N_MC*TERMS | Product terms, index m*TERMS+t |
| sum_out | output | N_MC | One sum per macrocell slot |

## Verification
Configuration loading and logic evaluation can fall in the same cycle. This happens when a fresh load begins on an array that is already valid, and when the final bit of a load is shifted while inputs are applied. The bench starts a reload on a live configuration and requires that the outputs drop to zero at that edge. It also watches `cfg_valid` on every bit of a load and requires it to appear exactly after the last bit. After each load, it sweeps all input combinations of a reduced array and compares every term and sum against values it computes from the image it shifted in.

// File: rtl/sop_pkg.sv
// sop_pkg: shared helpers for the sum-of-products array.
// Assumes the configuration image is laid out macrocell-major, then term,
// then input, with the true-literal bit below the complement-literal bit.
package sop_pkg;

    // Literal polarity selector used when indexing the image
    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } lit_pol_e;

    // Position in the image of one connection bit
    function automatic int img_index(input int terms, input int n_in,
                                     input int m, input int t,
                                     input int i, input lit_pol_e pol);
        return ((m * terms + t) * n_in + i) * 2 + int'(pol);
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
// sop_cfg_chain: serial loader for the connection image.
// Shifts cfg_bit in at the top of the vector so that the first bit loaded
// ends at index 0. A load counts only when cfg_load stays high for
// CFG_BITS consecutive clocks; a break discards the partial count.
module sop_cfg_chain #(
    parameter int CFG_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic                cfg_bit,
    output logic [CFG_BITS-1:0] image,
    output logic                valid
);
    localparam int CNT_W = $clog2(CFG_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_BITS - 1);

    logic [CNT_W-1:0] count_q;

    // Shift register holding the image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            image <= '0;
        end else if (cfg_load) begin
            image <= {cfg_bit, image[CFG_BITS-1:1]};
        end
    end

    // Bit counter and validity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            valid   <= 1'b0;
        end else if (cfg_load) begin
            if (count_q == LAST) begin
                count_q <= '0;
                valid   <= 1'b1;
            end else begin
                count_q <= count_q + 1'b1;
                valid   <= 1'b0;
            end
        end else begin
            count_q <= '0;
        end
    end

endmodule

// File: rtl/sop_lit_buf.sv
// sop_lit_buf: input buffer supplying both polarities of every input.
// Assumes nothing about the inputs; purely combinational.
module sop_lit_buf #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0] x,
    output logic [N_IN-1:0] lit_t,
    output logic [N_IN-1:0] lit_c
);
    // Drive both literal rails
    always_comb begin
        lit_t = x;
        lit_c = ~x;
    end

endmodule

// File: rtl/sop_pterm.sv
// sop_pterm: one product term of the programmable AND plane.
// A set select bit brings its literal into the AND; a clear bit removes it.
// With nothing selected the term is 1. Selecting both polarities of one
// input forces it to 0 through the ordinary AND.
module sop_pterm #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0] lit_t,
    input  logic [N_IN-1:0] lit_c,
    input  logic [N_IN-1:0] sel_t,
    input  logic [N_IN-1:0] sel_c,
    output logic            term
);
    logic [N_IN-1:0] pass;

    // Per-input gating: an unselected literal passes as 1
    always_comb begin
        pass = (~sel_t | lit_t) & (~sel_c | lit_c);
    end

    // Wide AND across all inputs
    always_comb begin
        term = &pass;
    end

endmodule

// File: rtl/sop_or_plane.sv
// sop_or_plane: fixed OR plane. Sum m combines the TERMS adjacent product
// terms starting at m*TERMS. The grouping is not programmable.
module sop_or_plane #(
    parameter int N_MC  = 2,
    parameter int TERMS = 8
) (
    input  logic [N_MC*TERMS-1:0] terms,
    output logic [N_MC-1:0]       sums
);
    for (genvar m = 0; m < N_MC; m++) begin : g_sum
        // OR of one macrocell's term group
        always_comb begin
            sums[m] = |terms[m*TERMS +: TERMS];
        end
    end

endmodule

// File: rtl/sop_array.sv
// sop_array: programmable AND / fixed OR array with serial configuration.
// Assumes the image is loaded before use; outputs read zero until a full
// load completes. From data_in to the outputs there is no register.
module sop_array
    import sop_pkg::*;
#(
    parameter int N_IN  = 20,
    parameter int N_MC  = 16,
    parameter int TERMS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic                  cfg_bit,
    output logic                  cfg_valid,
    input  logic [N_IN-1:0]       data_in,
    output logic [N_MC*TERMS-1:0] term_out,
    output logic [N_MC-1:0]       sum_out
);
    localparam int N_PT     = N_MC * TERMS;
    localparam int CFG_BITS = N_PT * N_IN * 2;

    logic [CFG_BITS-1:0] image;
    logic [N_IN-1:0]     lit_t;
    logic [N_IN-1:0]     lit_c;
    logic [N_PT-1:0]     pt_raw;
    logic [N_MC-1:0]     sum_raw;

    sop_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_bit  (cfg_bit),
        .image    (image),
        .valid    (cfg_valid)
    );

    sop_lit_buf #(.N_IN(N_IN)) u_buf (
        .x     (data_in),
        .lit_t (lit_t),
        .lit_c (lit_c)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        for (genvar t = 0; t < TERMS; t++) begin : g_pt
            logic [N_IN-1:0] sel_t;
            logic [N_IN-1:0] sel_c;

            for (genvar i = 0; i < N_IN; i++) begin : g_sel
                // Pick this term's connection bits out of the image
                always_comb begin
                    sel_t[i] = image[img_index(TERMS, N_IN, m, t, i, POL_TRUE)];
                    sel_c[i] = image[img_index(TERMS, N_IN, m, t, i, POL_COMP)];
                end
            end

            sop_pterm #(.N_IN(N_IN)) u_pt (
                .lit_t (lit_t),
                .lit_c (lit_c),
                .sel_t (sel_t),
                .sel_c (sel_c),
                .term  (pt_raw[m*TERMS + t])
            );
        end
    end

    sop_or_plane #(.N_MC(N_MC), .TERMS(TERMS)) u_or (
        .terms (pt_raw),
        .sums  (sum_raw)
    );

    // Hold outputs at zero until the image is complete
    always_comb begin
        term_out = cfg_valid ? pt_raw  : '0;
        sum_out  = cfg_valid ? sum_raw : '0;
    end

endmodule

// File: rtl/sop_array_chk.sv
// sop_array_chk: temporal checks on the array ports, bound to sop_array.
module sop_array_chk #(
    parameter int N_IN  = 20,
    parameter int N_MC  = 16,
    parameter int TERMS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_load,
    input logic                  cfg_valid,
    input logic [N_IN-1:0]       data_in,
    input logic [N_MC*TERMS-1:0] term_out,
    input logic [N_MC-1:0]       sum_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cfg_valid && sum_out == '0 && term_out == '0));

    // R2
    valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> $past(cfg_load));

    // R4
    reload_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_load) |=> (!cfg_valid && sum_out == '0));

    // R10
    stable_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_load) |=>
            ($stable(data_in) -> ($stable(sum_out) && $stable(term_out))));

    // R3
    valid_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !cfg_valid) |=> !cfg_valid);

endmodule

bind sop_array sop_array_chk #(.N_IN(N_IN), .N_MC(N_MC), .TERMS(TERMS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_valid (cfg_valid),
    .data_in   (data_in),
    .term_out  (term_out),
    .sum_out   (sum_out)
);

// File: tb/sim_sop_array.sv
module sim_sop_array;
    localparam int PERIOD = 10;
    localparam int NI  = 4;
    localparam int NM  = 2;
    localparam int TP  = 8;
    localparam int NPT = NM * TP;
    localparam int CB  = NPT * NI * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic cfg_bit = 1'b0;
    logic cfg_valid;
    logic [NI-1:0]  data_in = '0;
    logic [NPT-1:0] term_out;
    logic [NM-1:0]  sum_out;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;
    logic [CB-1:0] img;
    int unsigned seed = 32'h1234_5678;

    always #(PERIOD/2) clk = ~clk;

    sop_array #(.N_IN(NI), .N_MC(NM), .TERMS(TP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
        .cfg_valid(cfg_valid), .data_in(data_in),
        .term_out(term_out), .sum_out(sum_out)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_term(input logic [CB-1:0] im, input int m,
                                      input int t, input logic [NI-1:0] x);
        logic r = 1'b1;
        for (int i = 0; i < NI; i++) begin
            int b = ((m*TP + t)*NI + i)*2;
            if (im[b] && !x[i]) r = 1'b0;
            if (im[b+1] && x[i]) r = 1'b0;
        end
        return r;
    endfunction

    // Full contiguous load; R2 timing of cfg_valid checked on every bit
    task automatic load(input logic [CB-1:0] im);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int k = 0; k < CB; k++) begin
            cfg_bit = im[k];
            if (k > 0) check("R2 valid low mid-load", 32'(cfg_valid), 0);
            if (k == CB/2) check("R4 sums zero mid-load", 32'(sum_out), 0);
            @(negedge clk);
        end
        cfg_load = 1'b0;
        check("R2 valid after last bit", 32'(cfg_valid), 1);
    endtask

    // Exhaustive input sweep, no clock dependence (R10)
    task automatic sweep(input logic [CB-1:0] im, input string req);
        for (int v = 0; v < (1 << NI); v++) begin
            logic [NPT-1:0] et;
            logic [NM-1:0]  es;
            data_in = NI'(v);
            #1;
            es = '0;
            for (int m = 0; m < NM; m++)
                for (int t = 0; t < TP; t++) begin
                    et[m*TP+t] = exp_term(im, m, t, NI'(v));
                    es[m] = es[m] | et[m*TP+t];
                end
            check({req, " R8 terms"}, 32'(term_out), 32'(et));
            check({req, " R9 sums R10"}, 32'(sum_out), 32'(es));
        end
    endtask

    function automatic logic [CB-1:0] rand_img(input int dens);
        logic [CB-1:0] r;
        for (int k = 0; k < CB; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            r[k] = ((seed >> 16) % dens) == 0;
        end
        return r;
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            nbad++; nvec++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 valid", 32'(cfg_valid), 0);
        check("R1 sums", 32'(sum_out), 0);
        check("R1 terms", 32'(term_out), 0);

        // R3: interrupted load
        @(negedge clk);
        cfg_load = 1'b1;
        for (int k = 0; k < CB/3; k++) begin cfg_bit = 1'b0; @(negedge clk); end
        cfg_load = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 partial load invalid", 32'(cfg_valid), 0);
        check("R3 sums zero", 32'(sum_out), 0);

        // R5: empty image, every term 1
        img = '0;
        load(img);
        data_in = 4'hA; #1;
        check("R5 empty terms", 32'(term_out), 32'(16'hFFFF));
        sweep(img, "R5");

        // R6 on macrocell 0, R7 on macrocell 1
        img = '0;
        for (int t = 0; t < TP; t++) begin
            img[((0*TP + t)*NI + (t % NI))*2 + (t / NI)] = 1'b1;
            img[((1*TP + t)*NI + (t % NI))*2]     = 1'b1;
            img[((1*TP + t)*NI + (t % NI))*2 + 1] = 1'b1;
        end
        load(img);
        data_in = 4'b0101; #1;
        check("R6 single literals", 32'(term_out[7:0]), 32'(8'b1010_0101));
        check("R7 conflicting literals", 32'(term_out[15:8]), 0);
        check("R7 sum", 32'(sum_out[1]), 0);
        sweep(img, "R6 R7");

        // R9: one live term in macrocell 1 only
        img = '0;
        for (int t = 0; t < NPT; t++)
            if (t != 11) img[(t*NI)*2 + 0] = 1'b1;
        for (int t = 0; t < NPT; t++)
            if (t != 11) img[(t*NI)*2 + 1] = 1'b1;
        load(img);
        sweep(img, "R9 isolate");

        // R8 general patterns
        for (int r = 0; r < 6; r++) begin
            img = rand_img(3 + r*2);
            load(img);
            sweep(img, "R8 random");
        end

        // R4: reload on a live image clears validity at the first edge
        @(negedge clk);
        cfg_load = 1'b1; cfg_bit = 1'b0;
        @(negedge clk);
        check("R4 valid dropped on reload", 32'(cfg_valid), 0);
        check("R4 sums zero on reload", 32'(sum_out), 0);
        cfg_load = 1'b0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule